// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Shift Engine

This block moves short bursts of bits between a processor and a three-wire serial EEPROM. Software sees two registers: a control register, and a data byte register that can be read back at any time. Each accepted write to the control register starts one burst of 0 to 8 serial clocks. A read burst samples bits from the shared data line into the data register. A write burst shifts bits out of the data register onto the line. Chip-select and the ordering of multi-byte commands stay under software control, outside this block.

The serial clock comes from a divider on the system clock. Each SCLK phase lasts `HALF_DIV` system clocks, and SCLK idles low. The controller is a three-state machine:
- `ST_IDLE` waits for a command.
- `ST_LOW` is the low phase of SCLK. Outgoing data is presented here.
- `ST_HIGH` is the high phase of SCLK.

The transitions are:
- IDLE→LOW when a command with a non-zero count is accepted.
- LOW→HIGH on a divider tick. This is the rising SCLK edge, where a read samples its input.
- HIGH→LOW on a tick while bits remain. This is the falling edge, where a write shifts.
- HIGH→IDLE on the tick of the last bit.

A command with a zero count stays in IDLE. It only sets the drive state of the line and pulses the interrupt.

Top module: `sereep_shift_engine`

## Requirements
- R1: The control word is laid out as `ctrl_wdata[3:0]` = count, `[4]` = read (1) or write (0), and `[5]` = release the line after the burst (1) or keep driving it (0). A transfer starts only on a cycle with `ctrl_we` high while idle. A write to the data register updates `data_rdata` and starts nothing.
- R2: A burst issues exactly n rising SCLK edges, where n is the count value. Counts from 9 to 15 are treated as 8.
- R3: A write burst sends n bits MSB first on `sdata_o`, taken from bit 7 of the data register. The register shifts left with zero fill on each falling edge, so it ends holding `(d << n)` truncated to 8 bits.
- R4: A read burst samples `sdata_i` on each rising SCLK edge, MSB first. The data register is cleared when the burst starts, so it ends with the n bits right-justified and zeros above them.
- R5: During a read burst `sdata_oe` is 0. It stays 0 after the burst ends.
- R6: During a write burst `sdata_oe` is 1. After the burst, `sdata_oe` equals the inverse of the release bit.
- R7: A zero-count command issues no SCLK edge and leaves the data register unchanged. It sets `sdata_oe` to the inverse of the release bit and pulses `irq` in the next cycle.
- R8: `busy` is high for exactly 2·n·HALF_DIV cycles after an accepted command with n > 0. SCLK is low whenever `busy` is low, and after reset `busy`, `sclk`, `irq`, `sdata_oe` and the data register are all 0.
- R9: `irq` is high for one system clock per command. For a burst, that cycle is the one in which `busy` falls, and `irq` is never high while `busy` is high.
- R10: While `busy` is high, writes to the control register and to the data register are ignored, and the burst in progress completes unchanged.
- R11: Each SCLK phase lasts HALF_DIV system clocks and every burst starts with SCLK low. `sdata_o` changes only when SCLK falls, never while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 6 | Control word: release bit, read bit, count |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 8 | Data register write value |
| data_rdata | output | 8 | Data register contents |
| busy | output | 1 | Burst in progress |
| irq | output | 1 | Completion pulse |
| sclk | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data out |
| sdata_oe | output | 1 | Serial data output enable (1 = driven) |
| sdata_i | input | 1 | Serial data in |

## Verification
On every cycle the assertions check several properties:
- the line direction against the burst type;
- SCLK held low while idle, and at the start of each burst;
- `sdata_o` holding steady through each SCLK high phase;
- the interrupt coinciding with the fall of `busy`, and never overlapping it.

Only the bench's scenarios can show the rest. That covers the exact number of edges, the clamping of large counts, and the bit order and right-justification of the data. It also covers the final drive state for every combination of count, direction and release bit, and that writes made during a burst leave the burst unchanged.

// File: rtl/sereep_pkg.sv
package sereep_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } eng_state_t;

endpackage

// File: rtl/sereep_clkgen.sv
module sereep_clkgen #(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    generate
        if (HALF_DIV <= 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_count
            localparam int unsigned DW = $clog2(HALF_DIV);
            logic [DW-1:0] cnt_q;

            assign tick = (cnt_q == DW'(HALF_DIV - 1));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (clr || tick) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/sereep_shreg.sv
module sereep_shreg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift_in,
    input  logic              shift_out,
    input  logic              sin,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] q_r;

    assign q = q_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= '0;
        end else if (clear) begin
            q_r <= '0;
        end else if (load) begin
            q_r <= load_val;
        end else if (shift_in) begin
            q_r <= {q_r[DATA_W-2:0], sin};
        end else if (shift_out) begin
            q_r <= {q_r[DATA_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/sereep_fsm.sv
module sereep_fsm
    import sereep_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [CNT_W-1:0] cmd_cnt,
    input  logic             cmd_rd,
    input  logic             cmd_hiz,
    input  logic             data_we,
    input  logic             tick,
    output logic             busy,
    output logic             sclk,
    output logic             oe,
    output logic             irq,
    output logic             rd_mode,
    output logic             div_clr,
    output logic             sh_clear,
    output logic             sh_load,
    output logic             sh_in,
    output logic             sh_out
);
    eng_state_t       state_q, state_d;
    logic [CNT_W-1:0] bits_q, bits_d;
    logic             rd_q, rd_d;
    logic             hiz_q, hiz_d;
    logic             oe_q, oe_d;
    logic             irq_q, irq_d;
    logic [CNT_W-1:0] cnt_cl;

    assign cnt_cl = (cmd_cnt > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : cmd_cnt;

    always_comb begin
        state_d = state_q;
        bits_d  = bits_q;
        rd_d    = rd_q;
        hiz_d   = hiz_q;
        oe_d    = oe_q;
        irq_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_we) begin
                    if (cnt_cl == '0) begin
                        oe_d  = !cmd_hiz;
                        irq_d = 1'b1;
                    end else begin
                        state_d = ST_LOW;
                        bits_d  = cnt_cl;
                        rd_d    = cmd_rd;
                        hiz_d   = cmd_hiz;
                        oe_d    = !cmd_rd;
                    end
                end
            end
            ST_LOW: begin
                if (tick) begin
                    state_d = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    if (bits_q == CNT_W'(1)) begin
                        state_d = ST_IDLE;
                        irq_d   = 1'b1;
                        oe_d    = rd_q ? 1'b0 : !hiz_q;
                    end else begin
                        state_d = ST_LOW;
                        bits_d  = bits_q - 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bits_q  <= '0;
            rd_q    <= 1'b0;
            hiz_q   <= 1'b0;
            oe_q    <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            bits_q  <= bits_d;
            rd_q    <= rd_d;
            hiz_q   <= hiz_d;
            oe_q    <= oe_d;
            irq_q   <= irq_d;
        end
    end

    always_comb begin
        busy     = (state_q != ST_IDLE);
        sclk     = (state_q == ST_HIGH);
        oe       = oe_q;
        irq      = irq_q;
        rd_mode  = rd_q;
        div_clr  = (state_q == ST_IDLE);
        sh_clear = (state_q == ST_IDLE) && cmd_we && cmd_rd && (cnt_cl != '0);
        sh_load  = (state_q == ST_IDLE) && data_we;
        sh_in    = (state_q == ST_LOW) && tick && rd_q;
        sh_out   = (state_q == ST_HIGH) && tick && !rd_q;
    end
endmodule

// File: rtl/sereep_shift_engine.sv
module sereep_shift_engine #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned HALF_DIV = 2,
    localparam int unsigned CNT_W = $clog2(DATA_W + 1),
    localparam int unsigned CMD_W = CNT_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CMD_W-1:0]  ctrl_wdata,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_wdata,
    output logic [DATA_W-1:0] data_rdata,
    output logic              busy,
    output logic              irq,
    output logic              sclk,
    output logic              sdata_o,
    output logic              sdata_oe,
    input  logic              sdata_i
);
    logic tick, div_clr, rd_mode;
    logic sh_clear, sh_load, sh_in, sh_out;
    logic [DATA_W-1:0] shq;

    sereep_clkgen #(.HALF_DIV(HALF_DIV)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (div_clr),
        .tick (tick)
    );

    sereep_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_we  (ctrl_we),
        .cmd_cnt (ctrl_wdata[CNT_W-1:0]),
        .cmd_rd  (ctrl_wdata[CNT_W]),
        .cmd_hiz (ctrl_wdata[CNT_W+1]),
        .data_we (data_we),
        .tick    (tick),
        .busy    (busy),
        .sclk    (sclk),
        .oe      (sdata_oe),
        .irq     (irq),
        .rd_mode (rd_mode),
        .div_clr (div_clr),
        .sh_clear(sh_clear),
        .sh_load (sh_load),
        .sh_in   (sh_in),
        .sh_out  (sh_out)
    );

    sereep_shreg #(.DATA_W(DATA_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sh_clear),
        .load     (sh_load),
        .load_val (data_wdata),
        .shift_in (sh_in),
        .shift_out(sh_out),
        .sin      (sdata_i),
        .q        (shq)
    );

    assign data_rdata = shq;
    assign sdata_o    = shq[DATA_W-1];
endmodule

// File: rtl/sereep_chk.sv
module sereep_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic sclk,
    input logic irq,
    input logic sdata_o,
    input logic sdata_oe,
    input logic rd_mode
);
    // R5
    p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_mode) |-> !sdata_oe);

    // R6
    p_write_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rd_mode) |-> sdata_oe);

    // R8
    p_sclk_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    // R9
    p_irq_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq);

    // R9
    p_irq_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy);

    // R11
    p_start_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !sclk);

    // R11
    p_hold_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata_o));
endmodule

bind sereep_shift_engine sereep_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .sclk    (sclk),
    .irq     (irq),
    .sdata_o (sdata_o),
    .sdata_oe(sdata_oe),
    .rd_mode (rd_mode)
);

// File: tb/sim_sereep_shift_engine.sv
module sim_sereep_shift_engine;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 2;
    localparam int WIN = 2 * 8 * HALF + 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [5:0] ctrl_wdata = '0;
    logic       data_we = 1'b0;
    logic [7:0] data_wdata = '0;
    logic [7:0] data_rdata;
    logic       busy, irq, sclk, sdata_o, sdata_oe;
    logic       sdata_i = 1'b0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    sereep_shift_engine #(.DATA_W(8), .HALF_DIV(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .data_we(data_we), .data_wdata(data_wdata), .data_rdata(data_rdata),
        .busy(busy), .irq(irq), .sclk(sclk), .sdata_o(sdata_o),
        .sdata_oe(sdata_oe), .sdata_i(sdata_i)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    task automatic run_xfer(input int c, input bit rd, input bit hiz,
                            input logic [7:0] d, input logic [7:0] rpat,
                            input bit inject);
        int n, rises, hi_cyc, busy_cyc, irq_cyc, irq_busy, oe_bad, hold_bad;
        int exp_data, exp_cap, exp_oe;
        logic [7:0] cap;
        logic psclk, psd;
        bit injected, inj_clear;
        n = (c > 8) ? 8 : c;
        rises = 0; hi_cyc = 0; busy_cyc = 0; irq_cyc = 0; irq_busy = 0;
        oe_bad = 0; hold_bad = 0; cap = '0; injected = 0; inj_clear = 0;
        @(negedge clk);
        data_we = 1'b1; data_wdata = d; sdata_i = rpat[7];
        @(negedge clk);
        data_we = 1'b0;
        ctrl_we = 1'b1; ctrl_wdata = {hiz, rd, 4'(c)};
        psclk = 1'b0; psd = sdata_o;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (i == 0) ctrl_we = 1'b0;
            if (inj_clear) begin
                ctrl_we = 1'b0; data_we = 1'b0; inj_clear = 0;
            end
            if (sclk && !psclk) begin
                if (!rd) cap = {cap[6:0], sdata_o};
                rises++;
            end
            if (sclk) hi_cyc++;
            if (sclk && psclk && (sdata_o != psd)) hold_bad++;
            if (busy) begin
                busy_cyc++;
                if (sdata_oe != !rd) oe_bad++;
            end
            if (irq) begin
                irq_cyc++;
                if (busy) irq_busy++;
            end
            if (!sclk && rises < 8) sdata_i = rpat[7 - rises];
            if (inject && !injected && rises == 2 && !sclk) begin
                ctrl_we = 1'b1; ctrl_wdata = {~hiz, ~rd, 4'd8};
                data_we = 1'b1; data_wdata = ~d;
                injected = 1; inj_clear = 1;
            end
            psclk = sclk; psd = sdata_o;
        end
        if (!rd) exp_data = int'(8'(d << n));
        else if (n == 0) exp_data = int'(d);
        else exp_data = int'(rpat >> (8 - n));
        exp_cap = (n == 0) ? 0 : int'(d >> (8 - n));
        exp_oe = (rd && n > 0) ? 0 : int'(!hiz);
        check($sformatf("R2 rises c=%0d rd=%0d", c, rd), rises, n);
        check($sformatf("R8 busy cycles c=%0d", c), busy_cyc, 2 * n * HALF);
        check($sformatf("R11 high cycles c=%0d", c), hi_cyc, n * HALF);
        check($sformatf("R11 hold while high c=%0d", c), hold_bad, 0);
        check($sformatf("R9 irq count c=%0d", c), irq_cyc, 1);
        check($sformatf("R9 irq during busy c=%0d", c), irq_busy, 0);
        if (n == 0) begin
            check($sformatf("R7 data unchanged rd=%0d", rd), int'(data_rdata), exp_data);
            check($sformatf("R7 oe hiz=%0d", hiz), int'(sdata_oe), exp_oe);
        end else if (rd) begin
            check($sformatf("R4 read data c=%0d", c), int'(data_rdata), exp_data);
            check($sformatf("R5 oe during read c=%0d", c), oe_bad, 0);
            check($sformatf("R5 oe after read c=%0d", c), int'(sdata_oe), exp_oe);
        end else begin
            check($sformatf("R3 sent bits c=%0d", c), int'(cap), exp_cap);
            check($sformatf("R3 shifted data c=%0d", c), int'(data_rdata), exp_data);
            check($sformatf("R6 oe during write c=%0d", c), oe_bad, 0);
            check($sformatf("R6 oe after write c=%0d hiz=%0d", c, hiz), int'(sdata_oe), exp_oe);
        end
        if (inject) check($sformatf("R10 injected writes taken rd=%0d", rd), int'(injected), 1);
        check("R8 idle at end", int'(busy) + int'(sclk), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset busy", int'(busy), 0);
        check("R8 reset sclk", int'(sclk), 0);
        check("R8 reset irq", int'(irq), 0);
        check("R8 reset oe", int'(sdata_oe), 0);
        check("R8 reset data", int'(data_rdata), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: a data write alone starts nothing
        data_we = 1'b1; data_wdata = 8'hA5;
        @(negedge clk);
        data_we = 1'b0;
        begin
            int b, s, q;
            b = 0; s = 0; q = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                b += int'(busy); s += int'(sclk); q += int'(irq);
            end
            check("R1 no busy after data write", b, 0);
            check("R1 no sclk after data write", s, 0);
            check("R1 no irq after data write", q, 0);
            check("R1 data readback", int'(data_rdata), 8'hA5);
        end

        // R1 R2 R3 R4 R6 R7: sweep every count, direction and release bit
        for (int c = 0; c < 16; c++) begin
            for (int r = 0; r < 2; r++) begin
                for (int h = 0; h < 2; h++) begin
                    run_xfer(c, r[0], h[0], 8'(c * 53 + 150 + h * 17),
                             8'(c * 29 + 195 + h * 90), 1'b0);
                end
            end
        end

        // R10: writes during a burst are ignored
        run_xfer(8, 1'b0, 1'b1, 8'hB6, 8'h00, 1'b1);
        run_xfer(6, 1'b1, 1'b0, 8'h11, 8'h9D, 1'b1);
        run_xfer(12, 1'b0, 1'b0, 8'h4E, 8'h00, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule